// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Model

This block is a synthesizable model of a small pipelined synchronous burst SRAM with its full control front-end. On each rising clock edge it decides whether a new address is loaded, using two active-low address strobes that are gated differently and ranked by priority. It also samples three chip enables at that load, and then keeps the device selected or deselected for the burst that follows. While selected, every clock performs one access. The access is a write if a global or byte-lane write is requested and a read otherwise. Read data comes out one clock later.

The two low address bits come from a four-beat burst sequencer. A static order input selects either a linear sequence (wrap-around increment) or an interleaved sequence (start XOR beat index). The data bus is split into an input port, an output port and a drive flag in place of a tristate pin. The drive flag is gated without a clock by an active-low output enable. It is also masked on the first read clock that follows a deselected state. The array is parameterized in depth, lane count and lane width, with a default of 64 words of four 9-bit lanes.

Top module: `sbs_top`

## Requirements
- R1: An address is loaded with the device selected only when the enables read select-a low, select-b high and select-c low at that edge. A load with any enable inactive deselects the device: it performs no write, and the drive flag is low after that edge.
- R2: When both strobes are low and select-a is low, the processor strobe takes the load. A cycle loaded by the processor strobe is always a read, even if write enables are asserted.
- R3: The processor strobe is ignored while select-a is high. If the controller strobe is also high, the burst in progress continues as if no strobe had been given.
- R4: Between loads, changes on the three enables have no effect. A selected burst keeps reading and writing.
- R5: With the global write low, all lanes of the addressed word are written from wdata, whatever the byte write enable and lane selects are.
- R6: With the global write high and the byte write enable low, lane i (bits 9i+8 down to 9i) is written only where lane_sel_n[i] is low. A write cycle leaves the drive flag low after its edge.
- R7: The word read by an access at edge n appears on rdata after edge n and stays there until the next read.
- R8: The drive flag is forced low by out_en_n high with no clock needed, and follows again as soon as out_en_n goes low.
- R9: The drive flag stays low for the first read after a deselected state (or after reset), and is high for reads that follow a selected cycle.
- R10: A selected cycle with neither write enable low is a read. An unselected cycle writes nothing and leaves the drive flag low after its edge.
- R11: With linear_order high, a burst started at low bits s visits (s+k) mod 4 for beats k = 0..3, with the upper address bits held.
- R12: With linear_order low, a burst started at low bits s visits s XOR k for beats k = 0..3.
- R13: A selected cycle with step_n high and no load accesses the same address again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address, used at loads |
| proc_strb_n | input | 1 | Processor address strobe, active low, priority |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| en_a_n | input | 1 | Select-a, active low; also gates the processor strobe |
| en_b | input | 1 | Select-b, active high |
| en_c_n | input | 1 | Select-c, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_lane_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, unclocked |
| linear_order | input | 1 | Burst order strap: 1 linear, 0 interleaved |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_drive | output | 1 | High when rdata would be driven onto the bus |

## Verification
The bench aims at the strobe corner cases. Both strobes are asserted with write enables low, and a design that let the controller strobe win would overwrite the word. A processor strobe is given while select-a is high, and a design that failed to gate it would jump to a new address instead of stepping the burst. Partial-lane writes and a byte write with no lane selected expose wrong masking, and both burst orders are walked from a non-zero start to expose a wrong wrap or XOR. Deselect cycles carrying write requests, enable changes in the middle of a burst and the first-read masking are also driven. A design that sampled the enables every cycle, or drove data on the first read after deselect, would show a wrong drive flag or corrupted words.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;

  // Low address bits for beat idx of a burst started at start
  function automatic logic [BURST_W-1:0] beat_addr(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] idx,
    input logic               linear
  );
    if (linear) beat_addr = start + idx;
    else        beat_addr = start ^ idx;
  endfunction

endpackage

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
  import sbs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic               linear,
  input  logic [BURST_W-1:0] start,
  output logic [BURST_W-1:0] low_addr
);

  logic [BURST_W-1:0] start_q, start_d;
  logic [BURST_W-1:0] beat_q, beat_d;
  logic [BURST_W-1:0] beat_inc;

  assign beat_inc = beat_q + 1'b1;

  always_comb begin
    start_d = start_q;
    beat_d  = beat_q;
    if (load) begin
      start_d = start;
      beat_d  = '0;
    end else if (step) begin
      beat_d  = beat_inc;
    end
  end

  always_comb begin
    if (load)      low_addr = start;
    else if (step) low_addr = beat_addr(start_q, beat_inc, linear);
    else           low_addr = beat_addr(start_q, beat_q, linear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else begin
      start_q <= start_d;
      beat_q  <= beat_d;
    end
  end

endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proc_strb_n,
  input  logic             ctrl_strb_n,
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             en_c_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic             load,
  output logic             step,
  output logic             access,
  output logic [LANES-1:0] wr_lanes,
  output logic             rd_en,
  output logic             drive_ok
);

  logic      proc_take, ctrl_take, enables_ok;
  logic      sel_q, sel_d;
  logic      act_q;
  logic      rd_q, rd_d;
  logic      fresh_q, fresh_d;
  logic      wr_req;
  logic [LANES-1:0] lane_req;
  cyc_kind_e kind;

  // strobe decode: processor strobe needs select-a low and wins ties
  assign proc_take  = !proc_strb_n && !en_a_n;
  assign ctrl_take  = !ctrl_strb_n && !proc_take;
  assign load       = proc_take || ctrl_take;
  assign enables_ok = !en_a_n && en_b && !en_c_n;

  assign access = load ? enables_ok : sel_q;
  assign sel_d  = access;
  assign step   = !load && sel_q && !step_n;

  // write lane request
  always_comb begin
    if (!wr_all_n)       lane_req = '1;
    else if (!wr_lane_n) lane_req = ~lane_sel_n;
    else                 lane_req = '0;
  end
  assign wr_req = !wr_all_n || !wr_lane_n;

  always_comb begin
    if (!access)                 kind = CYC_IDLE;
    else if (wr_req && !proc_take) kind = CYC_WRITE;
    else                         kind = CYC_READ;
  end

  assign wr_lanes = (kind == CYC_WRITE) ? lane_req : '0;
  assign rd_en    = (kind == CYC_READ);
  assign rd_d     = rd_en;
  assign fresh_d  = access && !act_q;
  assign drive_ok = rd_q && !fresh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      act_q   <= access;
      rd_q    <= rd_d;
      fresh_q <= fresh_d;
    end
  end

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic                    rd_en,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_lanes[g]) begin
        mem[addr][g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rdata_q <= mem[addr];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/sbs_top.sv
module sbs_top
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    proc_strb_n,
  input  logic                    ctrl_strb_n,
  input  logic                    en_a_n,
  input  logic                    en_b,
  input  logic                    en_c_n,
  input  logic                    step_n,
  input  logic                    wr_all_n,
  input  logic                    wr_lane_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    out_en_n,
  input  logic                    linear_order,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_drive
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HIGH_W = ADDR_W - BURST_W;

  logic               load, step, access, rd_en, drive_ok;
  logic [LANES-1:0]   wr_lanes;
  logic [BURST_W-1:0] low_addr;
  logic [HIGH_W-1:0]  high_q, high_d;
  logic [ADDR_W-1:0]  eff_addr;

  sbs_ctrl #(.LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .proc_strb_n(proc_strb_n),
    .ctrl_strb_n(ctrl_strb_n),
    .en_a_n     (en_a_n),
    .en_b       (en_b),
    .en_c_n     (en_c_n),
    .step_n     (step_n),
    .wr_all_n   (wr_all_n),
    .wr_lane_n  (wr_lane_n),
    .lane_sel_n (lane_sel_n),
    .load       (load),
    .step       (step),
    .access     (access),
    .wr_lanes   (wr_lanes),
    .rd_en      (rd_en),
    .drive_ok   (drive_ok)
  );

  sbs_burst_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .linear  (linear_order),
    .start   (addr_i[BURST_W-1:0]),
    .low_addr(low_addr)
  );

  always_comb begin
    high_d = high_q;
    if (load) high_d = addr_i[ADDR_W-1:BURST_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) high_q <= '0;
    else        high_q <= high_d;
  end

  assign eff_addr = {high_d, low_addr};

  sbs_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk     (clk),
    .addr    (eff_addr),
    .wr_lanes(wr_lanes),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .rdata   (rdata)
  );

  assign rdata_drive = drive_ok && !out_en_n;

endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             proc_strb_n,
  input logic             en_a_n,
  input logic             out_en_n,
  input logic             access,
  input logic [LANES-1:0] wr_lanes,
  input logic             rdata_drive
);

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_drive);

  assert_no_drive_after_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> !rdata_drive);

  assert_first_read_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_drive |-> ($past(access) && $past(access, 2)));

  assert_no_drive_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_drive |-> ($past(wr_lanes) == '0));

  assert_proc_load_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strb_n && !en_a_n) |-> (wr_lanes == '0));

endmodule

bind sbs_top sbs_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .proc_strb_n(proc_strb_n),
  .en_a_n     (en_a_n),
  .out_en_n   (out_en_n),
  .access     (access),
  .wr_lanes   (wr_lanes),
  .rdata_drive(rdata_drive)
);

// File: tb/sim_sbs_top.sv
`timescale 1ns/100ps
module sim_sbs_top;

  logic        clk, rst_n;
  logic [5:0]  addr_i;
  logic        proc_strb_n, ctrl_strb_n, en_a_n, en_b, en_c_n, step_n;
  logic        wr_all_n, wr_lane_n, out_en_n, linear_order;
  logic [3:0]  lane_sel_n;
  logic [35:0] wdata, rdata;
  logic        rdata_drive;

  logic [35:0] ref_mem [64];
  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  sbs_top u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [35:0] pat(input int i);
    logic [8:0] v = 9'(i);
    pat = {v * 9'd3 + 9'd1, v + 9'h55, ~v, v * 9'd5};
  endfunction

  task automatic chk(input string req, input logic [35:0] got, input logic [35:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic pn, input logic cn, input logic c1n, input logic c2,
                     input logic c3n, input logic stn, input logic gwn, input logic bwen,
                     input logic [3:0] bs, input logic [5:0] a, input logic [35:0] d);
    proc_strb_n = pn; ctrl_strb_n = cn; en_a_n = c1n; en_b = c2; en_c_n = c3n;
    step_n = stn; wr_all_n = gwn; wr_lane_n = bwen; lane_sel_n = bs;
    addr_i = a; wdata = d;
    @(negedge clk);
  endtask

  task automatic ld(input logic [5:0] a, input logic gwn, input logic bwen,
                    input logic [3:0] bs, input logic [35:0] d);
    cyc(1, 0, 0, 1, 0, 1, gwn, bwen, bs, a, d);
  endtask

  task automatic rd_at(input logic [5:0] a);
    ld(a, 1, 1, 4'hf, '0);
  endtask

  task automatic cont(input logic stn, input logic gwn, input logic bwen,
                      input logic [3:0] bs, input logic [35:0] d);
    cyc(1, 1, 0, 1, 0, stn, gwn, bwen, bs, 6'd0, d);
  endtask

  task automatic desel();
    cyc(1, 0, 0, 0, 0, 1, 1, 1, 4'hf, 6'd0, '0);
  endtask

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] d,
                                        input logic [3:0] bs);
    merge = old;
    for (int l = 0; l < 4; l++) if (!bs[l]) merge[l*9 +: 9] = d[l*9 +: 9];
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; out_en_n = 1'b0; linear_order = 1'b1;
    proc_strb_n = 1; ctrl_strb_n = 1; en_a_n = 1; en_b = 0; en_c_n = 1;
    step_n = 1; wr_all_n = 1; wr_lane_n = 1; lane_sel_n = 4'hf; addr_i = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset drive", 36'(rdata_drive), 36'd0);
  endtask

  task automatic t_fill();
    desel();
    for (int i = 0; i < 64; i++) begin
      ld(6'(i), 0, 1, 4'hf, pat(i));
      ref_mem[i] = pat(i);
    end
    chk("R6 drive after write", 36'(rdata_drive), 36'd0);
  endtask

  task automatic t_pipe();
    desel();
    chk("R10 deselect drive", 36'(rdata_drive), 36'd0);
    rd_at(6'd5);
    chk("R7 read data", rdata, ref_mem[5]);
    chk("R9 first read masked", 36'(rdata_drive), 36'd0);
    cont(1, 1, 1, 4'hf, '0);
    chk("R13 hold address", rdata, ref_mem[5]);
    chk("R9 second read driven", 36'(rdata_drive), 36'd1);
  endtask

  task automatic t_linear();
    linear_order = 1'b1;
    rd_at(6'd6);
    chk("R11 beat0", rdata, ref_mem[6]);
    cont(0, 1, 1, 4'hf, '0); chk("R11 beat1", rdata, ref_mem[7]);
    cont(0, 1, 1, 4'hf, '0); chk("R11 beat2", rdata, ref_mem[4]);
    cont(0, 1, 1, 4'hf, '0); chk("R11 beat3", rdata, ref_mem[5]);
    chk("R11 drive", 36'(rdata_drive), 36'd1);
  endtask

  task automatic t_inter();
    linear_order = 1'b0;
    rd_at(6'd9);
    chk("R12 beat0", rdata, ref_mem[9]);
    cont(0, 1, 1, 4'hf, '0); chk("R12 beat1", rdata, ref_mem[8]);
    cont(0, 1, 1, 4'hf, '0); chk("R12 beat2", rdata, ref_mem[11]);
    cont(0, 1, 1, 4'hf, '0); chk("R12 beat3", rdata, ref_mem[10]);
    linear_order = 1'b1;
  endtask

  task automatic t_bytes();
    logic [35:0] d;
    d = 36'hA_BCDE_F012;
    ld(6'd20, 1, 0, 4'b1010, d);
    ref_mem[20] = merge(ref_mem[20], d, 4'b1010);
    chk("R6 drive after byte write", 36'(rdata_drive), 36'd0);
    cont(1, 1, 1, 4'hf, '0);
    chk("R6 lanes 0 and 2", rdata, ref_mem[20]);
    d = 36'h1_2345_6789;
    ld(6'd21, 0, 1, 4'hf, d); ref_mem[21] = d;
    cont(1, 1, 1, 4'hf, '0);
    chk("R5 global write all lanes", rdata, ref_mem[21]);
    d = 36'h5_5AA5_A55A;
    ld(6'd22, 0, 0, 4'b0111, d); ref_mem[22] = d;
    cont(1, 1, 1, 4'hf, '0);
    chk("R5 global overrides selects", rdata, ref_mem[22]);
    ld(6'd23, 1, 0, 4'hf, 36'hF_FFFF_FFFF);
    cont(1, 1, 1, 4'hf, '0);
    chk("R6 no lane selected", rdata, ref_mem[23]);
  endtask

  task automatic t_prio();
    rd_at(6'd29);
    cyc(0, 0, 0, 1, 0, 1, 0, 0, 4'h0, 6'd30, 36'h0_DEAD_BEEF);
    chk("R2 processor load reads", rdata, ref_mem[30]);
    chk("R2 processor load drives", 36'(rdata_drive), 36'd1);
    cont(1, 1, 1, 4'hf, '0);
    chk("R2 word unchanged", rdata, ref_mem[30]);
  endtask

  task automatic t_ignore();
    rd_at(6'd40);
    cyc(0, 1, 1, 1, 0, 0, 1, 1, 4'hf, 6'd50, '0);
    chk("R3 burst continues", rdata, ref_mem[41]);
    chk("R3 drive", 36'(rdata_drive), 36'd1);
  endtask

  task automatic t_hold();
    rd_at(6'd44);
    cyc(1, 1, 1, 0, 1, 0, 1, 1, 4'hf, 6'd0, '0);
    chk("R4 read despite enables", rdata, ref_mem[45]);
    chk("R4 drive", 36'(rdata_drive), 36'd1);
    cyc(1, 1, 1, 0, 1, 0, 0, 1, 4'hf, 6'd0, 36'h3_3333_3333);
    ref_mem[46] = 36'h3_3333_3333;
    cont(1, 1, 1, 4'hf, '0);
    chk("R4 write despite enables", rdata, ref_mem[46]);
  endtask

  task automatic t_oe();
    rd_at(6'd12);
    cont(1, 1, 1, 4'hf, '0);
    chk("R8 driven", 36'(rdata_drive), 36'd1);
    out_en_n = 1'b1; #0.4;
    chk("R8 disabled", 36'(rdata_drive), 36'd0);
    out_en_n = 1'b0; #0.4;
    chk("R8 re-enabled", 36'(rdata_drive), 36'd1);
  endtask

  task automatic t_desel();
    rd_at(6'd13);
    cyc(1, 0, 0, 0, 0, 1, 0, 1, 4'hf, 6'd50, 36'h7_7777_7777);
    chk("R10 drive after deselect", 36'(rdata_drive), 36'd0);
    cont(0, 0, 1, 4'hf, 36'h8_8888_8888);
    chk("R10 idle no drive", 36'(rdata_drive), 36'd0);
    rd_at(6'd50);
    chk("R10 no write while deselected", rdata, ref_mem[50]);
    chk("R9 masked after deselect", 36'(rdata_drive), 36'd0);
  endtask

  task automatic t_ce3();
    rd_at(6'd14);
    cyc(1, 0, 0, 1, 1, 1, 0, 1, 4'hf, 6'd60, 36'h9_9999_9999);
    chk("R1 select-c high deselects", 36'(rdata_drive), 36'd0);
    rd_at(6'd60);
    chk("R1 no write on rejected load", rdata, ref_mem[60]);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_pipe();
    t_linear();
    t_inter();
    t_bytes();
    t_prio();
    t_ignore();
    t_hold();
    t_oe();
    t_desel();
    t_ce3();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule